// File: doc/BRIEF.md
# PCI Configuration Base Address Register Set

This block holds the base address registers and the expansion ROM base register of one PCI function's configuration header. Each base address slot is described at elaboration time by a 32-bit configuration word. Bit 0 of that word selects the slot type: 1 for I/O space and 0 for memory space. The low field of the word is fixed: 2 bits for an I/O slot and 4 bits for a memory slot. That field always reads back exactly as written in the configuration word. Bit 1 of an I/O slot may therefore read as 1. The bits of the configuration word above the low field are the set of bits that software may write. Writing all ones and reading back gives the configuration word, and from that the decoded size.

The expansion ROM register takes its mask from a ROM size parameter. The size is rounded up to a power of two, with 2 KiB as the smallest size. Bit 0 is the ROM enable. Bits 10 to 1 always read 0, and the address bits below the rounded size read 0. A ROM size of 0 means there is no ROM, and the register then reads 0.

Access is a plain single-cycle register strobe. A dword index selects the register, and `cfg_wr` with `cfg_wdata` writes it on the rising clock edge. `cfg_rdata` is a combinational function of `cfg_idx` and the registered state. The access path has no handshake and no back-pressure: every strobe is accepted in the cycle it is presented. The base address slots sit at dword indices 4 to 9, in slot order. The ROM register sits at dword index 12. The decoded base and enable outputs come straight from the registers, so they change on the clock edge that takes the write.

Top module: `pci_bar_regs`

## Requirements
- R1: After reset, each base address slot reads back its fixed low field with all writable bits 0, the ROM register reads 0, and `rom_en` is 0.
- R2: A slot whose configuration word has bit 0 = 1 (I/O) always reads bits 1:0 equal to configuration bits 1:0, whatever is written. This includes the value binary 11.
- R3: A slot whose configuration word has bit 0 = 0 (memory) always reads bits 3:0 equal to configuration bits 3:0, whatever is written.
- R4: A write to slot s (index 4+s) stores the written bits where the configuration word above the low field is 1. Every other bit above the low field reads 0. Writing 0xFFFFFFFF therefore reads back the configuration word.
- R5: Slots numbered NUM_BARS and above (up to slot 5) read 0, ignore writes, and drive a base output of 0.
- R6: In the ROM register (index 12), only bit 0 and the address bits at or above log2 of the rounded ROM size are writable. Bits 10:1 always read 0.
- R7: The ROM size is rounded up to a power of two, with 2 KiB as the minimum. A 100000-byte ROM reads 0xFFFE0001 after all ones are written, and a 300-byte ROM reads 0xFFFFF801.
- R8: `bar_base[s]` equals slot s's read value with its fixed low field cleared. `rom_base` equals the ROM register with bit 0 cleared, and `rom_en` equals its bit 0. All of these change on the clock edge that takes the write, and not before it.
- R9: Indices other than 4 to 9 and 12 read 0, and writes to them change no register.
- R10: While `cfg_wr` is 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx | input | IDX_W | Dword index of the accessed register |
| cfg_wr | input | 1 | Write strobe, takes effect at the rising edge |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read value of the indexed register |
| bar_base | output | 6 x 32 | Decoded base address per slot, fixed low field cleared |
| rom_base | output | 32 | Decoded ROM base address, enable bit cleared |
| rom_en | output | 1 | ROM decode enable |

## Verification
A wrong writable mask or a corrupted slot register shows up on the next read of that index. It also shows up at once on `bar_base` after the write edge, because both come from the same flop. A lost fixed low field appears on any read of the slot, even straight after reset, without any write. A decode fault that sends a write to the wrong slot or to the ROM register shows up on the decoded outputs one edge later. So every internal fault becomes visible at the ports within one clock of the access that exposes it.

// File: rtl/pcibar_pkg.sv
package pcibar_pkg;
  localparam int DW            = 32;
  localparam int MAX_SLOTS     = 6;
  localparam int FIRST_BAR_IDX = 4;
  localparam int ROM_IDX       = 12;
  localparam int ROM_MIN_LOG2  = 11;

  localparam logic [DW-1:0] IO_FIXED  = 32'h0000_0003;
  localparam logic [DW-1:0] MEM_FIXED = 32'h0000_000F;

  // Low field held constant for a slot, picked by the type bit.
  function automatic logic [DW-1:0] fixed_bits(input logic [DW-1:0] cfg);
    return cfg[0] ? IO_FIXED : MEM_FIXED;
  endfunction

  // Address mask of a ROM of the given byte count, rounded up to a power of two.
  function automatic logic [DW-1:0] rom_addr_mask(input longint unsigned bytes);
    if (bytes == 0) return '0;
    for (int k = ROM_MIN_LOG2; k < DW; k++) begin
      if ((64'd1 << k) >= bytes) return ~(DW'((64'd1 << k) - 64'd1));
    end
    return '0;
  endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import pcibar_pkg::*;
#(
  parameter logic [DW-1:0] CFG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] base
);
  localparam logic [DW-1:0] FIXED = fixed_bits(CFG);
  localparam logic [DW-1:0] WMASK = CFG & ~FIXED;

  logic [DW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (wr_sel) addr_q <= wdata & WMASK;
  end

  assign rd_val = addr_q | (CFG & FIXED);
  assign base   = addr_q;

  // R4: a selected write lands masked on the next edge
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (base == ($past(wdata) & WMASK)));
  // R10: no strobe, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(rd_val));
  // R2 R3: fixed low field never follows the write data
  p_low_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> ((rd_val & FIXED) == (CFG & FIXED)));
endmodule

// File: rtl/rom_base_reg.sv
module rom_base_reg
  import pcibar_pkg::*;
#(
  parameter longint unsigned ROM_BYTES = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] base,
  output logic          en
);
  localparam logic [DW-1:0] AMASK = rom_addr_mask(ROM_BYTES);
  localparam logic [DW-1:0] WMASK = (AMASK != '0) ? (AMASK | DW'(1)) : '0;

  logic [DW-1:0] rom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rom_q <= '0;
    else if (wr_sel) rom_q <= wdata & WMASK;
  end

  assign rd_val = rom_q;
  assign base   = rom_q & AMASK;
  assign en     = rom_q[0];

  // R8: enable follows bit 0 of the write on the next edge
  p_rom_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (en == ($past(wdata[0]) & WMASK[0])));
  // R6: bits 10:1 never become set
  p_rom_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (rd_val[10:1] == '0));
  // R10: no strobe, no change
  p_rom_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(rd_val));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import pcibar_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic [MAX_SLOTS-1:0][DW-1:0] slot_rd,
  input  logic [DW-1:0]               rom_rd,
  output logic [DW-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (idx == IDX_W'(FIRST_BAR_IDX + i)) rdata = slot_rd[i];
    end
    if (idx == IDX_W'(ROM_IDX)) rdata = rom_rd;
  end
endmodule

// File: rtl/pci_bar_regs.sv
module pci_bar_regs
  import pcibar_pkg::*;
#(
  parameter int                         IDX_W     = 6,
  parameter int                         NUM_BARS  = 3,
  parameter logic [MAX_SLOTS-1:0][DW-1:0] BAR_CFG = {32'h0, 32'h0, 32'h0,
                                                     32'hFFF0_0000, 32'hFFFF_FF03, 32'hFFFF_F008},
  parameter longint unsigned            ROM_BYTES = 100000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic                         cfg_wr,
  input  logic [DW-1:0]                cfg_wdata,
  output logic [DW-1:0]                cfg_rdata,
  output logic [MAX_SLOTS-1:0][DW-1:0] bar_base,
  output logic [DW-1:0]                rom_base,
  output logic                         rom_en
);
  logic [MAX_SLOTS-1:0][DW-1:0] slot_rd;
  logic [MAX_SLOTS-1:0]         slot_wr;
  logic [DW-1:0]                rom_rd;
  logic                         rom_wr;
  logic                         idx_hit;

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
    localparam logic [DW-1:0] SCFG = (i < NUM_BARS) ? BAR_CFG[i] : '0;
    assign slot_wr[i] = cfg_wr && (cfg_idx == IDX_W'(FIRST_BAR_IDX + i));
    bar_slot #(.CFG(SCFG)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (slot_wr[i]),
      .wdata  (cfg_wdata),
      .rd_val (slot_rd[i]),
      .base   (bar_base[i])
    );
  end

  assign rom_wr = cfg_wr && (cfg_idx == IDX_W'(ROM_IDX));

  rom_base_reg #(.ROM_BYTES(ROM_BYTES)) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (rom_wr),
    .wdata  (cfg_wdata),
    .rd_val (rom_rd),
    .base   (rom_base),
    .en     (rom_en)
  );

  cfg_read_mux #(.IDX_W(IDX_W)) u_rmux (
    .idx     (cfg_idx),
    .slot_rd (slot_rd),
    .rom_rd  (rom_rd),
    .rdata   (cfg_rdata)
  );

  assign idx_hit = (slot_wr != '0) || rom_wr;

  // R9: strobes to unmapped indices leave every decoded output alone
  p_other_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !idx_hit) |=> ($stable(bar_base) && $stable(rom_base) && $stable(rom_en)));
  // R5: unused slots never decode a base
  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr[MAX_SLOTS-1] |=> (bar_base[MAX_SLOTS-1] == ((NUM_BARS >= MAX_SLOTS) ? bar_base[MAX_SLOTS-1] : '0)));
  // R8: the decoded base stays put until the write edge
  p_base_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(bar_base));
endmodule

// File: tb/test_pci_bar_regs.sv
module test_pci_bar_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam logic [5:0][31:0] CFGS = {32'h0, 32'h0, 32'h0,
                                       32'hFFF0_0000, 32'hFFFF_FF03, 32'hFFFF_F008};
  localparam logic [31:0] ROM_WM   = 32'hFFFE_0001; // R7: 100000 B -> 128 KiB
  localparam logic [31:0] ROM_WM_S = 32'hFFFF_F801; // R7: 300 B -> 2 KiB floor

  logic clk = 0, rst_n = 0, cfg_wr = 0;
  logic [5:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, rdata, rom_base, rdata_s, rom_base_s;
  logic [5:0][31:0] bar_base, bar_base_s;
  logic rom_en, rom_en_s;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_bar [6];
  logic [31:0] m_rom;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bar_regs i_pci_bar_regs (.clk, .rst_n, .cfg_idx, .cfg_wr, .cfg_wdata,
    .cfg_rdata(rdata), .bar_base, .rom_base, .rom_en);

  pci_bar_regs #(.NUM_BARS(1), .ROM_BYTES(300)) i_pci_bar_regs_small (.clk, .rst_n,
    .cfg_idx, .cfg_wr, .cfg_wdata, .cfg_rdata(rdata_s), .bar_base(bar_base_s),
    .rom_base(rom_base_s), .rom_en(rom_en_s));

  function automatic logic [31:0] fixm(input logic [31:0] c);
    return c[0] ? 32'h3 : 32'hF;
  endfunction
  function automatic logic [31:0] wmask(input int s);
    return (s < NB) ? (CFGS[s] & ~fixm(CFGS[s])) : 32'h0;
  endfunction
  function automatic logic [31:0] exp_rd(input int idx);
    if (idx >= 4 && idx <= 9) begin
      if (idx - 4 >= NB) return 32'h0;
      return m_bar[idx-4] | (CFGS[idx-4] & fixm(CFGS[idx-4]));
    end
    if (idx == 12) return m_rom;
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input int idx, input logic [31:0] d);
    if (idx >= 4 && idx <= 9) m_bar[idx-4] = d & wmask(idx-4);
    if (idx == 12) m_rom = d & ROM_WM;
  endtask

  task automatic do_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_idx = 6'(idx); cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    model_wr(idx, d);
  endtask

  task automatic rd_chk(input int idx, input string req);
    @(negedge clk);
    cfg_idx = 6'(idx); cfg_wr = 0;
    #1 chk(req, rdata, exp_rd(idx));
  endtask

  task automatic outs_chk(input string req);
    for (int s = 0; s < 6; s++) chk(req, bar_base[s], m_bar[s]);
    chk(req, rom_base, m_rom & 32'hFFFF_FFFE);
    chk(req, {31'h0, rom_en}, {31'h0, m_rom[0]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 6; s++) m_bar[s] = '0;
    m_rom = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 4; i <= 9; i++) rd_chk(i, "R1 reset read");
    rd_chk(12, "R1 rom reset");
    chk("R1 bar1 reset reads fixed 11", exp_rd(5), 32'h3);
    outs_chk("R1 outputs after reset");

    // R4 size probe, R2 I/O keeps 11, R3 memory keeps 1000
    for (int i = 4; i <= 9; i++) do_wr(i, 32'hFFFF_FFFF);
    for (int i = 4; i <= 9; i++) rd_chk(i, "R4 size probe");
    chk("R4 probe slot0", exp_rd(4), 32'hFFFF_F008);
    do_wr(5, 32'h0);
    rd_chk(5, "R2 io low bits stay 11");
    do_wr(4, 32'h1234_5677);
    rd_chk(4, "R3 mem low bits fixed");
    rd_chk(7, "R5 unused slot reads 0");
    outs_chk("R5 R8 decoded outputs");

    // R6 R7 ROM probe, both sizes
    do_wr(12, 32'hFFFF_FFFF);
    rd_chk(12, "R6 rom probe");
    chk("R7 rom 128K", rdata, 32'hFFFE_0001);
    chk("R7 rom 2K floor", rdata_s, ROM_WM_S);
    chk("R5 small unused slot1", bar_base_s[1], 32'h0);
    outs_chk("R8 rom outputs");

    // R8 timing: old value before edge, new after
    @(negedge clk);
    cfg_idx = 6'd6; cfg_wdata = 32'hABC0_0000; cfg_wr = 1;
    #1 chk("R8 base before edge", bar_base[2], m_bar[2]);
    @(negedge clk);
    cfg_wr = 0;
    model_wr(6, 32'hABC0_0000);
    chk("R8 base after edge", bar_base[2], 32'hABC0_0000);

    // R9 unmapped index writes
    do_wr(3, 32'hFFFF_FFFF);
    do_wr(13, 32'h0);
    rd_chk(3, "R9 unmapped read");
    outs_chk("R9 no change");

    // R10 data toggles without strobe
    @(negedge clk);
    cfg_idx = 6'd4; cfg_wdata = 32'h0; cfg_wr = 0;
    @(negedge clk);
    outs_chk("R10 no strobe");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int idx;
      idx = $urandom_range(0, 15);
      if ($urandom_range(0, 1) == 1) do_wr(idx, $urandom());
      else begin
        @(negedge clk);
        cfg_idx = 6'(idx); cfg_wdata = $urandom(); cfg_wr = 0;
        @(negedge clk);
      end
      rd_chk($urandom_range(0, 15), "R4 R9 random read");
      outs_chk("R8 random outputs");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule